// File: doc/BRIEF.md
# Write-Invalidate Line Coherence Agent

This block tracks the coherence state of one cached line for one core in a bus-based multicore. It follows a three-state write-invalidate protocol: Invalid, Shared (clean, other copies may exist) and Modified (dirty, sole copy). Two request streams reach it. The local processor issues reads and writes to the line. Other cores' bus transactions arrive as snoops. From these the agent computes the next line state. It also raises the bus actions the line needs: a read request, a read-for-ownership (write miss), an upgrade invalidate, a data supply to another core, or a write-back to memory.

The agent keeps no data, has no bus arbiter and has no shared-level storage. The surrounding logic grants the bus and returns fill data. The local processor holds its request until `cpu_done` is high. A snoop always takes effect on the state before a local request that arrives in the same cycle is judged. This lets two cores that race to write one line settle through the bus order. The core that loses the race drops to Invalid, and its pending upgrade becomes a write miss.

Top module: `msi_line_agent`

## Requirements
- R1: While `rst_n` is low and after its release, the line is Invalid, `bus_req` is low and `cpu_done` is low until a request arrives.
- R2: `line_state` encodes Invalid=0, Shared=1, Modified=2. `bus_cmd` and `snp_cmd` encode none=0, read=1, read-for-ownership=2, upgrade=3. `bus_cmd` is 0 whenever `bus_req` is low.
- R3: A local read to an Invalid line raises `bus_req` with command read from the next cycle. After the grant the agent waits for `fill_valid`. In that fill cycle `cpu_done` is high, and the line is Shared from the next cycle.
- R4: A local write to an Invalid line issues read-for-ownership. In the fill cycle `cpu_done` is high and the line becomes Modified.
- R5: A local write to a Shared line issues upgrade. `cpu_done` is high in the grant cycle and the line becomes Modified without waiting for a fill.
- R6: A read to a Shared or Modified line, or a write to a Modified line, gives `cpu_done` in the same cycle. It raises no bus request and leaves the state unchanged.
- R7: A Shared line that snoops read-for-ownership or upgrade becomes Invalid. A snooped read leaves it Shared, with `snp_supply` and `snp_wb` low.
- R8: A Modified line that snoops a read raises `snp_supply` and `snp_wb` in that cycle and becomes Shared.
- R9: A Modified line that snoops read-for-ownership or upgrade raises `snp_supply` with `snp_wb` low and becomes Invalid.
- R10: If a snooped invalidate hits a Shared line while its own upgrade waits for the grant, the line becomes Invalid. The pending command changes to read-for-ownership and later completes through a fill into Modified.
- R11: Snoops to an Invalid line raise neither `snp_supply` nor `snp_wb` and leave it Invalid.
- R12: When a snoop and a local request arrive in the same cycle, the request is judged against the state after the snoop. For example, a write to a Modified line that snoops a read issues an upgrade instead of hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cpu_req | input | 1 | Local access request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_done | output | 1 | Local access completes this cycle |
| line_state | output | 2 | Current coherence state |
| bus_req | output | 1 | Agent asks for the bus |
| bus_gnt | input | 1 | Bus granted; the command is issued in this cycle |
| bus_cmd | output | 2 | Command offered on the bus |
| snp_valid | input | 1 | Another core's transaction targets this line |
| snp_cmd | input | 2 | Snooped command |
| snp_supply | output | 1 | Agent supplies the line's data to the bus |
| snp_wb | output | 1 | Agent also writes the data back to memory |
| fill_valid | input | 1 | Fill data for the outstanding miss returns |

## Verification
The hardest case to reach is the lost write race. The line must be Shared with an upgrade already waiting for the grant. An invalidate from another core must then be snooped before the grant arrives. Directed steps build this order on purpose: a read fill, a local write, one cycle of withheld grant with a snooped read-for-ownership, then the grant and the fill. Long random runs withhold grants, send snoops at random and make local requests land in the same cycle as snoops. These runs also reach the race and the same-cycle ordering of R12 in many states.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_FILL = 2'd2
  } phase_e;
endpackage

// File: rtl/msi_snoop_side.sv
module msi_snoop_side
  import msi_pkg::*;
(
  input  line_st_e cur_st,
  input  logic     snp_valid,
  input  bus_cmd_e snp_cmd,
  output line_st_e post_st,
  output logic     snp_supply,
  output logic     snp_wb,
  output logic     lost_copy
);
  logic snp_act;

  assign snp_act = snp_valid && (snp_cmd != BC_NONE);

  always_comb begin
    post_st    = cur_st;
    snp_supply = 1'b0;
    snp_wb     = 1'b0;
    if (snp_act) begin
      case (cur_st)
        LS_M: begin
          snp_supply = 1'b1;
          if (snp_cmd == BC_RD) begin
            snp_wb  = 1'b1;
            post_st = LS_S;
          end else begin
            post_st = LS_I;
          end
        end
        LS_S: begin
          if (snp_cmd != BC_RD) post_st = LS_I;
        end
        default: post_st = cur_st;
      endcase
    end
  end

  assign lost_copy = (post_st == LS_I) && (cur_st != LS_I);
endmodule

// File: rtl/msi_cpu_side.sv
module msi_cpu_side
  import msi_pkg::*;
(
  input  line_st_e post_st,
  input  logic     idle,
  input  logic     cpu_req,
  input  logic     cpu_wr,
  output logic     hit_done,
  output logic     start,
  output bus_cmd_e start_cmd
);
  always_comb begin
    hit_done  = 1'b0;
    start     = 1'b0;
    start_cmd = BC_NONE;
    if (idle && cpu_req) begin
      if (cpu_wr) begin
        case (post_st)
          LS_M:    hit_done = 1'b1;
          LS_S:    begin start = 1'b1; start_cmd = BC_UPG; end
          default: begin start = 1'b1; start_cmd = BC_RDX; end
        endcase
      end else begin
        if (post_st == LS_I) begin
          start     = 1'b1;
          start_cmd = BC_RD;
        end else begin
          hit_done = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msi_miss_tracker.sv
module msi_miss_tracker
  import msi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  bus_cmd_e start_cmd,
  input  logic     lost_copy,
  input  logic     bus_gnt,
  input  logic     fill_valid,
  output logic     idle,
  output logic     bus_req,
  output bus_cmd_e bus_cmd,
  output bus_cmd_e pend_cmd,
  output logic     upg_granted,
  output logic     fill_done
);
  phase_e   phase_q, phase_d;
  bus_cmd_e cmd_q, cmd_d;
  logic     cmd_en;

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    cmd_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ARB;
          cmd_d   = start_cmd;
          cmd_en  = 1'b1;
        end
      end
      PH_ARB: begin
        if (lost_copy && cmd_q == BC_UPG) begin
          cmd_d  = BC_RDX;
          cmd_en = 1'b1;
        end else if (bus_gnt) begin
          phase_d = (cmd_q == BC_UPG) ? PH_IDLE : PH_FILL;
        end
      end
      PH_FILL: begin
        if (fill_valid) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= BC_NONE;
    end else begin
      phase_q <= phase_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign idle        = (phase_q == PH_IDLE);
  assign bus_req     = (phase_q == PH_ARB);
  assign bus_cmd     = bus_req ? cmd_q : BC_NONE;
  assign pend_cmd    = cmd_q;
  assign upg_granted = bus_req && bus_gnt && (cmd_q == BC_UPG) && !lost_copy;
  assign fill_done   = (phase_q == PH_FILL) && fill_valid;

  // R10: a lost upgrade turns into a write miss still waiting for the bus
  assert_demote_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ARB && cmd_q == BC_UPG && lost_copy) |=> (bus_req && bus_cmd == BC_RDX));
endmodule

// File: rtl/msi_line_agent.sv
module msi_line_agent
  import msi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_wr,
  output logic       cpu_done,
  output logic [1:0] line_state,
  output logic       bus_req,
  input  logic       bus_gnt,
  output logic [1:0] bus_cmd,
  input  logic       snp_valid,
  input  logic [1:0] snp_cmd,
  output logic       snp_supply,
  output logic       snp_wb,
  input  logic       fill_valid
);
  line_st_e state_q, state_d, post_st;
  bus_cmd_e start_cmd, bus_cmd_e_w, pend_cmd;
  logic     lost_copy, idle, hit_done, start, upg_granted, fill_done;

  msi_snoop_side u_snoop (
    .cur_st     (state_q),
    .snp_valid  (snp_valid),
    .snp_cmd    (bus_cmd_e'(snp_cmd)),
    .post_st    (post_st),
    .snp_supply (snp_supply),
    .snp_wb     (snp_wb),
    .lost_copy  (lost_copy)
  );

  msi_cpu_side u_cpu (
    .post_st   (post_st),
    .idle      (idle),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .hit_done  (hit_done),
    .start     (start),
    .start_cmd (start_cmd)
  );

  msi_miss_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_cmd   (start_cmd),
    .lost_copy   (lost_copy),
    .bus_gnt     (bus_gnt),
    .fill_valid  (fill_valid),
    .idle        (idle),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd_e_w),
    .pend_cmd    (pend_cmd),
    .upg_granted (upg_granted),
    .fill_done   (fill_done)
  );

  always_comb begin
    if (fill_done)        state_d = (pend_cmd == BC_RD) ? LS_S : LS_M;
    else if (upg_granted) state_d = LS_M;
    else                  state_d = post_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_I;
    else        state_q <= state_d;
  end

  assign cpu_done   = hit_done || upg_granted || fill_done;
  assign line_state = state_q;
  assign bus_cmd    = bus_cmd_e_w;

  // R3: a read request is only offered for an Invalid line
  assert_rd_from_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_RD) |-> (line_state == LS_I));
  // R5: an upgrade is only offered while the line is Shared
  assert_upg_from_shr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BC_UPG) |-> (line_state == LS_S));
  // R4: a finished write leaves the line Modified
  assert_wr_done_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_wr) |=> (line_state == LS_M));
  // R8: Modified line snooping a read ends Shared
  assert_mod_rd_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_RD && line_state == LS_M) |=> (line_state == LS_S));
  // R7: any valid line snooping an invalidating command ends Invalid
  assert_inv_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPG) && line_state != LS_I)
      |=> (line_state == LS_I));
endmodule

// File: tb/msi_line_agent_tb.sv
`timescale 1ns/1ps
module msi_line_agent_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_req, cpu_wr, bus_gnt, snp_valid, fill_valid;
  logic [1:0] snp_cmd;
  logic       cpu_done, bus_req, snp_supply, snp_wb;
  logic [1:0] line_state, bus_cmd;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  int  m_st, m_ph, m_cmd;
  bit  last_done;

  always #4 clk = ~clk;

  msi_line_agent u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_done(cpu_done), .line_state(line_state), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_supply(snp_supply), .snp_wb(snp_wb),
    .fill_valid(fill_valid)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected line state after a snoop (R7, R8, R9, R11)
  function automatic int snoop_post(int st, bit sv, int sc);
    if (!sv || sc == 0) return st;
    if (st == 2) return (sc == 1) ? 1 : 0;
    if (st == 1 && sc != 1) return 0;
    return st;
  endfunction

  task automatic step(string tag, bit req, bit wr, bit sv, int sc, bit gnt, bit fv);
    int post, scmd, n_st;
    bit sup, wbx, lost, hit, start, upg, fd, e_req;
    @(negedge clk);
    cpu_req = req; cpu_wr = wr; snp_valid = sv; snp_cmd = 2'(sc);
    bus_gnt = gnt; fill_valid = fv;
    #1;
    post  = snoop_post(m_st, sv, sc);
    sup   = sv && sc != 0 && m_st == 2;
    wbx   = sup && sc == 1;
    lost  = (post == 0) && (m_st != 0);
    e_req = (m_ph == 1);
    hit = 0; start = 0; scmd = 0;
    if (m_ph == 0 && req) begin
      if (wr) begin
        if (post == 2) hit = 1;
        else begin start = 1; scmd = (post == 1) ? 3 : 2; end
      end else begin
        if (post == 0) begin start = 1; scmd = 1; end
        else hit = 1;
      end
    end
    upg = (m_ph == 1) && gnt && (m_cmd == 3) && !lost;
    fd  = (m_ph == 2) && fv;
    chk(tag, "line_state", line_state, m_st);
    chk(tag, "bus_req", bus_req, e_req);
    chk(tag, "bus_cmd", bus_cmd, e_req ? m_cmd : 0);
    chk(tag, "snp_supply", snp_supply, sup);
    chk(tag, "snp_wb", snp_wb, wbx);
    chk(tag, "cpu_done", cpu_done, hit || upg || fd);
    last_done = hit || upg || fd;
    n_st = fd ? ((m_cmd == 1) ? 1 : 2) : (upg ? 2 : post);
    case (m_ph)
      0: if (start) begin m_ph = 1; m_cmd = scmd; end
      1: begin
        if (lost && m_cmd == 3) m_cmd = 2;
        else if (gnt) m_ph = (m_cmd == 3) ? 0 : 2;
      end
      default: if (fv) m_ph = 0;
    endcase
    m_st = n_st;
  endtask

  task automatic idle_step(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit hold_req, hold_wr;
    rst_n = 0; cpu_req = 0; cpu_wr = 0; snp_valid = 0; snp_cmd = 0;
    bus_gnt = 0; fill_valid = 0;
    m_st = 0; m_ph = 0; m_cmd = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset line_state", line_state, 0);
    chk("R1", "reset bus_req", bus_req, 0);
    chk("R1", "reset cpu_done", cpu_done, 0);
    @(negedge clk) rst_n = 1;
    idle_step("R1");

    // R3 read miss from Invalid, delayed grant then fill
    step("R3", 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 1, 0);
    step("R3", 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 1);
    idle_step("R2");
    chk("R3", "state after read fill", line_state, 1);
    // R6 read hit in Shared
    step("R6", 1, 0, 0, 0, 0, 0);
    // R7 snooped read keeps Shared, snooped read-for-ownership kills it
    step("R7", 0, 0, 1, 1, 0, 0);
    step("R7", 0, 0, 1, 2, 0, 0);
    idle_step("R7");
    chk("R7", "state after invalidate", line_state, 0);
    // R11 snoops on Invalid
    step("R11", 0, 0, 1, 1, 0, 0);
    step("R11", 0, 0, 1, 3, 0, 0);
    // R4 write miss
    step("R4", 1, 1, 0, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 1, 0);
    step("R4", 1, 1, 0, 0, 0, 1);
    idle_step("R4");
    chk("R4", "state after write fill", line_state, 2);
    // R6 hits in Modified
    step("R6", 1, 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 0);
    // R8 snooped read on Modified
    step("R8", 0, 0, 1, 1, 0, 0);
    idle_step("R8");
    chk("R8", "state after snooped read", line_state, 1);
    // R5 upgrade from Shared
    step("R5", 1, 1, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 0, 1, 0);
    idle_step("R5");
    chk("R5", "state after upgrade", line_state, 2);
    // R9 snooped upgrade on Modified
    step("R9", 0, 0, 1, 3, 0, 0);
    idle_step("R9");
    // R10 lost race
    step("R10", 1, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 1, 0);
    step("R10", 1, 0, 0, 0, 0, 1);
    step("R10", 1, 1, 0, 0, 0, 0);
    step("R10", 1, 1, 1, 2, 0, 0);
    step("R10", 1, 1, 0, 0, 0, 0);
    chk("R10", "demoted command", bus_cmd, 2);
    step("R10", 1, 1, 0, 0, 1, 0);
    step("R10", 1, 1, 0, 0, 0, 1);
    idle_step("R10");
    chk("R10", "state after lost race", line_state, 2);
    // R12 write to Modified with concurrent snooped read
    step("R12", 1, 1, 1, 1, 0, 0);
    step("R12", 1, 1, 0, 0, 1, 0);
    idle_step("R12");

    // Random traffic with a fixed seed
    void'($urandom(32'd1234));
    hold_req = 0; hold_wr = 0;
    for (int i = 0; i < 4000; i++) begin
      bit g, sv, fv;
      int sc;
      if (!hold_req && ($urandom % 3) == 0) begin
        hold_req = 1; hold_wr = $urandom % 2;
      end
      g  = (m_ph == 1) && (($urandom % 3) == 0);
      sv = !g && (($urandom % 4) == 0);
      sc = sv ? (1 + ($urandom % 3)) : 0;
      fv = (m_ph == 2) && (($urandom % 2) == 0);
      step("R12", hold_req, hold_wr, sv, sc, g, fv);
      if (last_done) hold_req = 0;
    end
    idle_step("R2");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule